// File: doc/BRIEF.md
# Randomized page-mapping flash translator

This block translates host page numbers into physical flash pages. It sits between a host request port and a flash port that moves one page per operation. A page is modelled as one `DATA_W`-bit word. Three tables live in on-chip registers: the logical-to-physical map with a written flag per logical page, a used flag per physical page, and a reverse map from physical page to owning logical page. Reads and writes find their physical page with one direct index into the map, with no search.

A write does not go to a fixed place. A free-running maximal-length LFSR, reduced modulo the physical page count, picks the target page. The page the logical page held before is released first. If the pick is occupied by another logical page, its contents are read into a one-page buffer, programmed into the next free page found by an upward wrapping scan, and the owner's map entry is redirected. Only then is the host data programmed into the picked page. One physical page is kept in reserve, so there are `PHYS_PAGES-1` logical pages and a free page always exists.

The host side uses a valid/ready request and a one-cycle done pulse with read data. The flash side issues one read or program request at a time and holds it until acknowledged.

Top module: `ftl_xlate`

## Requirements
- R1: After reset the host port shows ready high, done low, and no flash request is raised.
- R2: Reading a logical page that was never written returns all ones, issues no flash operation, and raises done 2 clock edges after the edge that accepts the request.
- R3: Reading a written logical page issues exactly one flash read (fl_write=0) at the physical page last recorded for it and returns the data read.
- R4: A write whose picked page is free issues exactly one flash program (fl_write=1) carrying the host data, at a page index below PHYS_PAGES.
- R5: A write whose picked page P holds another logical page issues, in order, a flash read of P, a program of that data into the first free page scanning upward from P+1 with wrap to 0, and a program of the host data into P.
- R6: On a rewrite, the logical page's previous physical page counts as free when the pick is made, so picking it causes no relocation.
- R7: After a relocation, the displaced logical page reads back its unchanged data from its new physical page.
- R8: A flash request keeps its direction, page and data stable until acknowledged, and no request is raised while the host port is ready.
- R9: Done is a one-cycle pulse in the cycle after the acknowledge that ends the last flash operation, and the port is ready again in the following cycle.
- R10: All PHYS_PAGES-1 logical pages can hold data at the same time and each reads back its own last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Controller idle and able to take a request |
| h_write | input | 1 | 1 = write, 0 = read |
| h_lpage | input | PW | Logical page number, below PHYS_PAGES-1 |
| h_wdata | input | DATA_W | Write data |
| h_done | output | 1 | One-cycle completion pulse |
| h_rdata | output | DATA_W | Read data, valid with h_done on a read |
| fl_req | output | 1 | Flash request valid |
| fl_write | output | 1 | 1 = page program, 0 = page read |
| fl_page | output | PW | Physical page index |
| fl_wdata | output | DATA_W | Program data |
| fl_ack | input | 1 | Flash acknowledge, one cycle, ends the request |
| fl_rdata | input | DATA_W | Page read data, valid with fl_ack |

## Verification
Two latencies are fixed. A read of an unwritten page completes 2 edges after acceptance. Any request served by flash completes in the cycle right after its final acknowledge. The bench stamps each cycle, records the acceptance cycle and the acknowledge cycle, and has the scoreboard monitor compare the done cycle against the due value while it pops the expected read data. The bench flash model logs every operation. After each request the driver derives the expected sequence of operations and their pages from its own occupancy model, keyed on the page the final program chose, and varies the acknowledge latency from 1 to 3 cycles.

// File: rtl/ftl_pkg.sv
package ftl_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LOOKUP, S_CHOOSE, S_FIND, S_RREAD,
    S_RPROG, S_PROG, S_HREAD, S_RESP
  } ftl_state_e;

  function automatic int lfsr_mask_bits(input int w);
    case (w)
      8:       return 'hB8;
      10:      return 'h240;
      12:      return 'hE08;
      default: return 'hB400;
    endcase
  endfunction
endpackage

// File: rtl/ftl_lfsr.sv
module ftl_lfsr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] MASK = W'(ftl_pkg::lfsr_mask_bits(W));

  logic [W-1:0] s_q, s_d;

  always_comb begin
    s_d = s_q >> 1;
    if (s_q[0]) s_d = s_d ^ MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  s_q <= W'(1);
    else if (en) s_q <= s_d;
  end

  assign value = s_q;
endmodule

// File: rtl/ftl_tables.sv
module ftl_tables #(
  parameter int PHYS_PAGES = 8,
  parameter int PW         = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PW-1:0]         lidx,
  output logic [PW-1:0]         l2p_rd,
  output logic                  lmapped,
  output logic [PHYS_PAGES-1:0] used,
  input  logic                  free_en,
  input  logic [PW-1:0]         free_page,
  input  logic                  reloc_en,
  input  logic [PW-1:0]         reloc_src,
  input  logic [PW-1:0]         reloc_dst,
  input  logic                  map_en,
  input  logic [PW-1:0]         map_lpage,
  input  logic [PW-1:0]         map_page
);
  localparam int LOG_PAGES = PHYS_PAGES - 1;

  logic [PW-1:0] l2p   [LOG_PAGES];
  logic          lval  [LOG_PAGES];
  logic [PW-1:0] owner [PHYS_PAGES];
  logic [PW-1:0] reloc_owner;

  assign reloc_owner = owner[reloc_src];
  assign l2p_rd      = l2p[lidx];
  assign lmapped     = lval[lidx];

  for (genvar gl = 0; gl < LOG_PAGES; gl++) begin : g_log
    logic [PW-1:0] ent_q;
    logic          val_q;
    logic          set_map, set_reloc;
    assign set_map   = map_en && (map_lpage == PW'(gl));
    assign set_reloc = reloc_en && (reloc_owner == PW'(gl));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
        val_q <= 1'b0;
      end else if (set_map) begin
        ent_q <= map_page;
        val_q <= 1'b1;
      end else if (set_reloc) begin
        ent_q <= reloc_dst;
      end
    end
    assign l2p[gl]  = ent_q;
    assign lval[gl] = val_q;
  end

  for (genvar gp = 0; gp < PHYS_PAGES; gp++) begin : g_phys
    logic [PW-1:0] own_q;
    logic          used_q;
    logic          hit_map, hit_reloc, hit_free;
    assign hit_map   = map_en && (map_page == PW'(gp));
    assign hit_reloc = reloc_en && (reloc_dst == PW'(gp));
    assign hit_free  = free_en && (free_page == PW'(gp));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_q  <= '0;
        used_q <= 1'b0;
      end else if (hit_map) begin
        own_q  <= map_lpage;
        used_q <= 1'b1;
      end else if (hit_reloc) begin
        own_q  <= reloc_owner;
        used_q <= 1'b1;
      end else if (hit_free) begin
        used_q <= 1'b0;
      end
    end
    assign owner[gp] = own_q;
    assign used[gp]  = used_q;
  end
endmodule

// File: rtl/ftl_xlate.sv
module ftl_xlate
  import ftl_pkg::*;
#(
  parameter  int PHYS_PAGES = 8,
  parameter  int DATA_W     = 32,
  parameter  int LFSR_W     = 16,
  localparam int PW         = $clog2(PHYS_PAGES)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic [PW-1:0]     h_lpage,
  input  logic [DATA_W-1:0] h_wdata,
  output logic              h_done,
  output logic [DATA_W-1:0] h_rdata,
  output logic              fl_req,
  output logic              fl_write,
  output logic [PW-1:0]     fl_page,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic              fl_ack,
  input  logic [DATA_W-1:0] fl_rdata
);
  localparam logic [PW-1:0] LAST_PAGE = PW'(PHYS_PAGES - 1);

  // reset: asynchronous assertion, synchronous release
  logic rs1_q, rs2_q, rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_n = rs2_q;

  ftl_state_e st_q, st_d;
  logic              wr_q;
  logic [PW-1:0]     lpage_q, target_q, scan_q, rdpage_q, pick, pick_next, scan_next;
  logic [DATA_W-1:0] wdata_q, buf_q, rdata_q;
  logic [LFSR_W-1:0] rnd;
  logic [PW-1:0]     l2p_rd;
  logic              lmapped;
  logic [PHYS_PAGES-1:0] used;
  logic free_en, reloc_en, map_en;
  logic accept;

  ftl_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .value(rnd)
  );

  ftl_tables #(.PHYS_PAGES(PHYS_PAGES), .PW(PW)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .lidx(lpage_q), .l2p_rd(l2p_rd), .lmapped(lmapped), .used(used),
    .free_en(free_en), .free_page(l2p_rd),
    .reloc_en(reloc_en), .reloc_src(target_q), .reloc_dst(scan_q),
    .map_en(map_en), .map_lpage(lpage_q), .map_page(target_q)
  );

  assign pick      = PW'(rnd % LFSR_W'(PHYS_PAGES));
  assign pick_next = (pick == LAST_PAGE) ? '0 : pick + PW'(1);
  assign scan_next = (scan_q == LAST_PAGE) ? '0 : scan_q + PW'(1);
  assign accept    = (st_q == S_IDLE) && h_valid;

  assign free_en  = (st_q == S_LOOKUP) && wr_q && lmapped;
  assign reloc_en = (st_q == S_RPROG) && fl_ack;
  assign map_en   = (st_q == S_PROG) && fl_ack;

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:   if (h_valid) st_d = S_LOOKUP;
      S_LOOKUP: st_d = wr_q ? S_CHOOSE : (lmapped ? S_HREAD : S_RESP);
      S_CHOOSE: st_d = used[pick] ? S_FIND : S_PROG;
      S_FIND:   if (!used[scan_q]) st_d = S_RREAD;
      S_RREAD:  if (fl_ack) st_d = S_RPROG;
      S_RPROG:  if (fl_ack) st_d = S_PROG;
      S_PROG:   if (fl_ack) st_d = S_RESP;
      S_HREAD:  if (fl_ack) st_d = S_RESP;
      S_RESP:   st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      wr_q     <= 1'b0;
      lpage_q  <= '0;
      wdata_q  <= '0;
      target_q <= '0;
      scan_q   <= '0;
      rdpage_q <= '0;
      buf_q    <= '0;
      rdata_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        wr_q    <= h_write;
        lpage_q <= h_lpage;
        wdata_q <= h_wdata;
      end
      if (st_q == S_LOOKUP && !wr_q) begin
        rdpage_q <= l2p_rd;
        if (!lmapped) rdata_q <= '1;
      end
      if (st_q == S_CHOOSE) begin
        target_q <= pick;
        scan_q   <= pick_next;
      end
      if (st_q == S_FIND && used[scan_q]) scan_q <= scan_next;
      if (st_q == S_RREAD && fl_ack) buf_q <= fl_rdata;
      if (st_q == S_HREAD && fl_ack) rdata_q <= fl_rdata;
    end
  end

  // flash request decode
  always_comb begin
    fl_req   = 1'b0;
    fl_write = 1'b0;
    fl_page  = target_q;
    fl_wdata = wdata_q;
    case (st_q)
      S_HREAD: begin fl_req = 1'b1; fl_page = rdpage_q; end
      S_RREAD: begin fl_req = 1'b1; end
      S_RPROG: begin fl_req = 1'b1; fl_write = 1'b1; fl_page = scan_q; fl_wdata = buf_q; end
      S_PROG:  begin fl_req = 1'b1; fl_write = 1'b1; end
      default: ;
    endcase
  end

  assign h_ready = (st_q == S_IDLE);
  assign h_done  = (st_q == S_RESP);
  assign h_rdata = rdata_q;
endmodule

// File: rtl/ftl_xlate_chk.sv
module ftl_xlate_chk #(
  parameter int PHYS_PAGES = 8,
  parameter int DATA_W     = 32,
  parameter int PW         = 3
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              h_ready,
  input logic              h_done,
  input logic              fl_req,
  input logic              fl_write,
  input logic [PW-1:0]     fl_page,
  input logic [DATA_W-1:0] fl_wdata,
  input logic              fl_ack
);
  // R8
  fl_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    fl_req && !fl_ack |=> fl_req && $stable(fl_write) && $stable(fl_page) && $stable(fl_wdata));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    h_ready |-> !fl_req);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    h_done |=> !h_done);

  // R9
  done_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    h_done |=> h_ready);

  // R4
  page_range_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    fl_req |-> (int'(fl_page) < PHYS_PAGES));
endmodule

bind ftl_xlate ftl_xlate_chk #(.PHYS_PAGES(PHYS_PAGES), .DATA_W(DATA_W), .PW(PW)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .h_ready(h_ready), .h_done(h_done),
  .fl_req(fl_req), .fl_write(fl_write), .fl_page(fl_page),
  .fl_wdata(fl_wdata), .fl_ack(fl_ack)
);

// File: tb/ftl_xlate_tb.sv
module ftl_xlate_tb;
  localparam int PHYS = 8;
  localparam int LOGP = PHYS - 1;
  localparam int DW   = 32;
  localparam int PW   = $clog2(PHYS);

  logic clk, rst_ni;
  logic h_valid, h_ready, h_write, h_done;
  logic [PW-1:0] h_lpage;
  logic [DW-1:0] h_wdata, h_rdata;
  logic fl_req, fl_write, fl_ack;
  logic [PW-1:0] fl_page;
  logic [DW-1:0] fl_wdata, fl_rdata;

  ftl_xlate #(.PHYS_PAGES(PHYS), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_ni(rst_ni), .h_valid(h_valid), .h_ready(h_ready),
    .h_write(h_write), .h_lpage(h_lpage), .h_wdata(h_wdata),
    .h_done(h_done), .h_rdata(h_rdata), .fl_req(fl_req),
    .fl_write(fl_write), .fl_page(fl_page), .fl_wdata(fl_wdata),
    .fl_ack(fl_ack), .fl_rdata(fl_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, ack_cyc = -10, last_acc = 0, collisions = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flash model with operation log
  logic [DW-1:0] fmem [PHYS];
  bit       op_w [$];
  int       op_p [$];
  logic [DW-1:0] op_d [$];
  int lat = 1, wcnt = 0;

  initial begin
    for (int i = 0; i < PHYS; i++) fmem[i] = '0;
    fl_ack = 1'b0;
    fl_rdata = '0;
    forever begin
      @(negedge clk);
      if (fl_ack) fl_ack = 1'b0;
      else if (fl_req) begin
        if (wcnt < lat - 1) wcnt++;
        else begin
          wcnt = 0;
          lat = (lat % 3) + 1;
          op_w.push_back(fl_write);
          op_p.push_back(int'(fl_page));
          op_d.push_back(fl_write ? fl_wdata : fmem[fl_page]);
          if (fl_write) fmem[fl_page] = fl_wdata;
          else fl_rdata = fmem[fl_page];
          fl_ack = 1'b1;
          ack_cyc = cyc;
        end
      end
    end
  end

  // scoreboard: kind 0 write, 1 flash-served read, 2 unwritten read
  int            exp_kind [$];
  logic [DW-1:0] exp_data [$];
  string         exp_tag  [$];

  initial begin
    forever begin
      @(negedge clk);
      if (h_done) begin
        if (exp_kind.size() == 0) chk(1'b0, "R9", "done without request", 1, 0);
        else begin
          int k;
          logic [DW-1:0] d;
          string t;
          k = exp_kind.pop_front();
          d = exp_data.pop_front();
          t = exp_tag.pop_front();
          if (k != 0) chk(h_rdata == d, t, "read data", h_rdata, d);
          if (k == 2) chk(cyc == last_acc + 2, "R2", "done latency", cyc - last_acc, 2);
          else chk(cyc == ack_cyc + 1, "R9", "done after final ack", cyc - ack_cyc, 1);
        end
      end
    end
  end

  int model [LOGP];
  logic [DW-1:0] refd [LOGP];

  task automatic host_req(input bit wr, input int lp, input logic [DW-1:0] d);
    op_w.delete(); op_p.delete(); op_d.delete();
    h_valid = 1'b1; h_write = wr; h_lpage = PW'(lp); h_wdata = d;
    while (!h_ready) @(negedge clk);
    last_acc = cyc;
    @(negedge clk);
    h_valid = 1'b0;
    while (!h_done) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int owner_of(input int p);
    for (int l = 0; l < LOGP; l++) if (model[l] == p) return l;
    return -1;
  endfunction

  task automatic do_read(input int lp, input string tag);
    bit mapped;
    mapped = (model[lp] >= 0);
    exp_kind.push_back(mapped ? 1 : 2);
    exp_data.push_back(mapped ? refd[lp] : '1);
    exp_tag.push_back(tag);
    host_req(1'b0, lp, '0);
    if (!mapped) chk(op_w.size() == 0, "R2", "flash ops on unwritten read", op_w.size(), 0);
    else begin
      chk(op_w.size() == 1, "R3", "flash op count", op_w.size(), 1);
      if (op_w.size() == 1) begin
        chk(op_w[0] == 1'b0, "R3", "op is read", op_w[0], 0);
        chk(op_p[0] == model[lp], "R3", "read page", op_p[0], model[lp]);
      end
    end
  endtask

  task automatic do_write(input int lp, input logic [DW-1:0] d);
    int n, c, old, own, f;
    exp_kind.push_back(0);
    exp_data.push_back('0);
    exp_tag.push_back("R4");
    host_req(1'b1, lp, d);
    n = op_w.size();
    if (n == 0) begin
      chk(1'b0, "R4", "no flash op on write", 0, 1);
      return;
    end
    c = op_p[n-1];
    chk(op_w[n-1] && op_d[n-1] == d, "R4", "final program data", op_d[n-1], d);
    chk(c < PHYS, "R4", "page range", c, PHYS - 1);
    old = model[lp];
    model[lp] = -1;                       // R6: own old page is free
    own = owner_of(c);
    if (own < 0) begin
      chk(n == 1, (c == old) ? "R6" : "R4", "ops for free pick", n, 1);
    end else begin
      collisions++;
      f = -1;
      for (int k = 1; k < PHYS && f < 0; k++)
        if (owner_of((c + k) % PHYS) < 0) f = (c + k) % PHYS;
      chk(n == 3, "R5", "ops for occupied pick", n, 3);
      if (n == 3) begin
        chk(!op_w[0] && op_p[0] == c, "R5", "relocation read page", op_p[0], c);
        chk(op_w[1] && op_p[1] == f, "R5", "relocation target page", op_p[1], f);
        chk(op_d[1] == refd[own], "R5", "relocated data", op_d[1], refd[own]);
      end
      model[own] = f;
    end
    model[lp] = c;
    refd[lp] = d;
  endtask

  initial begin
    h_valid = 1'b0; h_write = 1'b0; h_lpage = '0; h_wdata = '0;
    for (int l = 0; l < LOGP; l++) begin model[l] = -1; refd[l] = '0; end
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(h_ready == 1'b1, "R1", "ready after reset", h_ready, 1);
    chk(h_done == 1'b0, "R1", "done after reset", h_done, 0);
    chk(fl_req == 1'b0, "R1", "flash request after reset", fl_req, 0);
    // R2
    for (int l = 0; l < LOGP; l++) do_read(l, "R2");
    // R10: fill every logical page
    for (int l = 0; l < LOGP; l++) do_write(l, 32'hC0DE_0000 + 32'(l * 17));
    for (int l = 0; l < LOGP; l++) do_read(l, "R10");
    // R7: rewrites force relocations; displaced pages must keep data
    for (int i = 0; i < 60; i++) begin
      do_write((i * 3 + i / 7) % LOGP, 32'hA5A5_0000 ^ 32'(i * 1021));
      if (i % 6 == 5) for (int l = 0; l < LOGP; l++) do_read(l, "R7");
    end
    chk(collisions > 0, "R5", "relocations seen", collisions, 1);
    for (int l = 0; l < LOGP; l++) do_read(l, "R3");
    repeat (2) @(negedge clk);
    chk(exp_kind.size() == 0, "R9", "responses outstanding", exp_kind.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule